// File: doc/BRIEF.md
# Synchronous Serial Burst Transmitter

This block is a master-mode, 8-bit clocked serial port. It moves bytes out on a data line and takes bytes in on a second line, least significant bit first. It drives its own serial clock from a programmable rate divider. The block runs on a base clock that is one third of a CPU cycle. The serial clock period is 4 × (divider + 1) base clocks, so the shortest period is 4/3 of a CPU cycle.

A 32-slot byte buffer feeds the shifter. A single start strobe sends from 1 to 32 consecutive bytes, with no gap in the serial clock between bytes. Each byte received during the burst replaces the buffer slot that its transmitted byte came from. The host loads the buffer and reads it back through a simple write/read port. It supplies the byte count and the divider value, and it watches the busy and done outputs.

Top module: `sio_burst_top`

## Requirements
- R1: After reset, sck_o and sdo_o are high and busy_o and done_o are low. While idle, sck_o and sdo_o stay high.
- R2: An accepted start pulls sck_o low at that clock edge. sck_o then alternates, staying low for 2 × (div_i + 1) base clocks and then high for the same count, so one serial clock period is 4 × (div_i + 1) base clocks.
- R3: During a burst, serial bit b (counted from 0) is bit b mod 8 of buffer slot b / 8, so each byte goes out least significant bit first. sdo_o changes only at the edge where sck_o falls.
- R4: sdi_i is captured at each edge where sck_o rises. The first sampled bit becomes bit 0. After the eighth rising edge of a byte, the assembled byte is written into the slot that byte was sent from.
- R5: A burst sends len_i + 1 bytes, where len_i is 5 bits (0 means 1 byte, 31 means 32 bytes), with no extra serial clock period between bytes. Slots above len_i are left unchanged.
- R6: At the last rising edge of the burst, busy_o drops and done_o rises. done_o stays high until the next accepted start, which clears it.
- R7: A start while busy_o is high is ignored. len_i and div_i are latched only at an accepted start, so later changes to them, or a repeated start, leave the running burst unchanged.
- R8: With buf_we_i high at a clock edge, buf_wdata_i is stored in slot buf_addr_i. buf_rdata_o shows slot buf_addr_i combinationally. A write from the shifter in the same cycle to the same slot takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock, one third of a CPU cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_we_i | input | 1 | Host buffer write enable |
| buf_addr_i | input | 5 | Host buffer slot address |
| buf_wdata_i | input | 8 | Host buffer write data |
| buf_rdata_o | output | 8 | Buffer contents at buf_addr_i |
| len_i | input | 5 | Burst length minus one |
| div_i | input | 8 | Rate divider value |
| start_i | input | 1 | Start strobe |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Last burst finished |
| sck_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
A wrong half-period counter or phase bit shows up on sck_o at the first edge where the low or high phase should end, within 2 × (div + 1) base clocks of start. A wrong bit or byte index puts the wrong level on sdo_o at the next falling edge. It also makes busy_o fall and done_o rise too early or too late. Receive errors stay inside the buffer until the burst ends, so they appear only when the slots are read back after done_o rises. The bench compares every output with its model on every cycle and reads back every slot after each burst.

// File: rtl/sio_burst_pkg.sv
package sio_burst_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 32;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned BIT_W  = $clog2(DATA_W);
  localparam int unsigned CNT_W  = DIV_W + 1;
endpackage

// File: rtl/sio_rate_gen.sv
module sio_rate_gen #(
  parameter int unsigned DIV_W = 8,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;

  // half period = 2*(div+1) cycles -> reload 2*div+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= {div_i, 1'b1};
      reload_q <= {div_i, 1'b1};
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/sio_shift_eng.sv
module sio_shift_eng #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_next_o
);
  logic [DATA_W-1:0] tx_q, rx_q;

  assign rx_next_o = {sdi_i, rx_q[DATA_W-1:1]};
  assign tx_bit_o  = tx_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)        tx_q <= ld_data_i;
      else if (shift_i)  tx_q <= {1'b0, tx_q[DATA_W-1:1]};
      if (sample_i)      rx_q <= rx_next_o;
    end
  end
endmodule

// File: rtl/sio_burst_buf.sv
module sio_burst_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              eng_we_i,
  input  logic [ADDR_W-1:0] eng_waddr_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  input  logic [ADDR_W-1:0] eng_raddr_i,
  output logic [DATA_W-1:0] eng_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (eng_we_i && eng_waddr_i == ADDR_W'(i))
        mem_q[i] <= eng_wdata_i;
      else if (host_we_i && host_addr_i == ADDR_W'(i))
        mem_q[i] <= host_wdata_i;
    end
  end

  assign host_rdata_o = mem_q[host_addr_i];
  assign eng_rdata_o  = mem_q[eng_raddr_i];
endmodule

// File: rtl/sio_burst_top.sv
module sio_burst_top
  import sio_burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_we_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic              busy_q, done_q, sck_q;
  logic [ADDR_W-1:0] len_q, byte_q, ld_addr;
  logic [BIT_W-1:0]  bit_q;
  logic              start_acc, tick, rise, fall, last_bit, last_byte;
  logic              ld, shift, eng_we, tx_bit;
  logic [DATA_W-1:0] ld_data, rx_next;

  assign start_acc = start_i && !busy_q;
  assign rise      = tick && !sck_q;
  assign fall      = tick && sck_q;
  assign last_bit  = (bit_q == BIT_W'(DATA_W - 1));
  assign last_byte = (byte_q == len_q);
  assign ld        = start_acc || (fall && last_bit);
  assign shift     = fall && !last_bit;
  assign eng_we    = rise && last_bit;
  assign ld_addr   = start_acc ? '0 : ADDR_W'(byte_q + 1'b1);

  sio_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_acc),
    .div_i  (div_i),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  sio_shift_eng #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld),
    .ld_data_i (ld_data),
    .shift_i   (shift),
    .sample_i  (rise),
    .sdi_i     (sdi_i),
    .tx_bit_o  (tx_bit),
    .rx_next_o (rx_next)
  );

  sio_burst_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i        (clk_i),
    .host_we_i    (buf_we_i),
    .host_addr_i  (buf_addr_i),
    .host_wdata_i (buf_wdata_i),
    .host_rdata_o (buf_rdata_o),
    .eng_we_i     (eng_we),
    .eng_waddr_i  (byte_q),
    .eng_wdata_i  (rx_next),
    .eng_raddr_i  (ld_addr),
    .eng_rdata_o  (ld_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b1;
      len_q  <= '0;
      byte_q <= '0;
      bit_q  <= '0;
    end else if (start_acc) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      len_q  <= len_i;
      byte_q <= '0;
      bit_q  <= '0;
    end else if (rise) begin
      sck_q <= 1'b1;
      if (last_bit && last_byte) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else if (fall) begin
      sck_q <= 1'b0;
      bit_q <= bit_q + 1'b1;  // wraps to 0 after the last bit
      if (last_bit) byte_q <= byte_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign sdo_o  = busy_q ? tx_bit : 1'b1;
endmodule

// File: rtl/sio_burst_chk.sv
module sio_burst_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sck_o,
  input logic sdo_o
);
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o && sdo_o));

  a_r2_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |=> !sck_o);

  a_r2_rise_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $past(busy_o));

  a_r3_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$fell(sck_o)) |-> $stable(sdo_o));

  a_r6_end_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && sck_o));

  a_r6_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind sio_burst_top sio_burst_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sck_o   (sck_o),
  .sdo_o   (sdo_o)
);

// File: tb/tb_sio_burst_top.sv
module tb_sio_burst_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       buf_we_i = 1'b0, start_i = 1'b0, sdi_i = 1'b0;
  logic [4:0] buf_addr_i = '0, len_i = '0;
  logic [7:0] buf_wdata_i = '0, div_i = '0;
  logic [7:0] buf_rdata_o;
  logic       busy_o, done_o, sck_o, sdo_o;

  int checks = 0, failures = 0;
  logic [7:0] mem [32];

  sio_burst_top dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rx_byte(int k, int seed);
    return 8'((k * 37 + seed * 11 + 5) ^ (seed << 3));
  endfunction

  task automatic host_write(int a, logic [7:0] d);
    @(negedge clk_i);
    buf_we_i = 1'b1; buf_addr_i = 5'(a); buf_wdata_i = d;
    @(posedge clk_i);
    #1 buf_we_i = 1'b0;
  endtask

  task automatic run_burst(int len, int dv, bit poke, int seed);
    int p = 4 * (dv + 1);
    int h = p / 2;
    int nbits = 8 * (len + 1);
    int last = (nbits - 1) * p + h;
    @(negedge clk_i);
    len_i = 5'(len); div_i = 8'(dv); start_i = 1'b1;
    sdi_i = rx_byte(0, seed)[0];
    @(posedge clk_i);
    for (int t = 0; t <= last; t++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      begin
        int b = t / p;
        bit run = (t < last);
        chk("R2 sck", int'(sck_o), run ? int'((t % p) >= h) : 1);
        chk("R5 busy", int'(busy_o), int'(run));
        chk("R6 done", int'(done_o), int'(!run));
        chk("R3 sdo", int'(sdo_o), run ? int'(mem[b / 8][b % 8]) : 1);
      end
      if (poke && t == 3 * p + 1) begin  // R7: ignored restart with new settings
        start_i = 1'b1; len_i = 5'(len ^ 5'h1f); div_i = 8'(dv + 7);
      end
      begin
        int nb = (t + 1) / p;
        if (nb < nbits) sdi_i = rx_byte(nb / 8, seed)[nb % 8];
      end
    end
    for (int k = 0; k <= len; k++) mem[k] = rx_byte(k, seed);
    repeat (3) @(negedge clk_i);
    chk("R6 done hold", int'(done_o), 1);
    chk("R1 idle sck", int'(sck_o), 1);
    for (int k = 0; k < 32; k++) begin
      buf_addr_i = 5'(k);
      #1;
      chk(k <= len ? "R4 rx slot" : "R5 slot untouched", int'(buf_rdata_o), int'(mem[k]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset sck", int'(sck_o), 1);
    chk("R1 reset sdo", int'(sdo_o), 1);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 32; k++) begin
      mem[k] = 8'((k * 29 + 7) ^ 8'hA5);
      host_write(k, mem[k]);
    end
    for (int k = 0; k < 32; k += 5) begin
      @(negedge clk_i);
      buf_addr_i = 5'(k);
      #1 chk("R8 readback", int'(buf_rdata_o), int'(mem[k]));
    end
    run_burst(0, 0, 1'b1, 1);
    run_burst(3, 2, 1'b1, 2);
    run_burst(31, 0, 1'b0, 3);
    run_burst(1, 255, 1'b1, 4);
    run_burst(4, 1, 1'b0, 5);
    host_write(9, 8'h3C);
    mem[9] = 8'h3C;
    @(negedge clk_i);
    buf_addr_i = 5'd9;
    #1 chk("R8 write after burst", int'(buf_rdata_o), 8'h3C);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule